// File: doc/BRIEF.md
# DDR Mode Register Decoder

This block shadows the mode register of a DDR SDRAM device, either inside a device model or inside a controller that keeps a copy of what it has programmed. Each mode-register write arrives as a one-cycle strobe together with a 14-bit address word. The low seven bits carry the configuration: burst length, burst ordering and read latency. The upper seven bits select the operating mode. An all-zero upper field is a normal write. A lone one in bit 8 requests a DLL reset. Every other upper pattern is a reserved or test encoding and is refused.

A write is accepted only when its upper bits are normal or DLL-reset and both of its low code fields are legal. An accepted write updates the stored configuration one clock later. A refused write raises a one-cycle error pulse and leaves the configuration untouched. An accepted DLL-reset write emits a one-cycle DLL-reset pulse. It also arms a tracker that expects the next command to be a normal-mode write. Any other command that arrives while the tracker is armed raises a one-cycle sequencing-violation pulse. Another strobe input reports the device's non-mode-register commands, so that they can count as violations.

Top module: `ddr_mode_decoder`

## Requirements
- R1: After reset the outputs show burst length 2, sequential ordering, read latency 4 half-clocks, `dll_pending` low, and all three pulse outputs low.
- R2: An accepted write loads burst length from address bits 2..0 in the cycle after the strobe: code 1 gives 2, code 2 gives 4 and code 3 gives 8.
- R3: An accepted write loads burst ordering from address bit 3 in the cycle after the strobe: 0 gives sequential (`burst_interleave` low) and 1 gives interleaved (high).
- R4: An accepted write loads read latency from address bits 6..4, given in half clocks, in the cycle after the strobe: code 5 gives 3 (1.5 clk), code 2 gives 4 (2 clk), code 6 gives 5 (2.5 clk) and code 3 gives 6 (3 clk).
- R5: A write with bits 13..7 equal to 0000010 (bit 8 set, the others clear) and legal low fields is accepted. In the next cycle it pulses `dll_reset_pulse` high for one cycle and sets `dll_pending`.
- R6: A write whose bits 13..7 are neither 0000000 nor 0000010 pulses `reserved_err` in the next cycle. It changes no configuration output, raises no DLL-reset pulse and leaves `dll_pending` unchanged.
- R7: A write with a burst-length code outside {1,2,3} or a latency code outside {2,3,5,6} is refused in the same way as in R6.
- R8: While `dll_pending` is high, any command other than an accepted normal write pulses `seq_violation` in the next cycle. Such a command is a strobe on `other_cmd_stb`, a refused write or a DLL-reset write. After it, `dll_pending` stays high.
- R9: An accepted normal write (bits 13..7 all zero) clears `dll_pending` in the next cycle and raises no violation.
- R10: A strobe on `other_cmd_stb` has no effect on any output while `dll_pending` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrs_stb | input | 1 | Mode-register write strobe |
| other_cmd_stb | input | 1 | Strobe for any other device command |
| addr | input | 14 | Address word of the mode-register write |
| burst_len | output | 4 | Stored burst length in beats (2, 4 or 8) |
| burst_interleave | output | 1 | Stored burst ordering, 1 = interleaved |
| rd_lat_half | output | 3 | Stored read latency in half clocks |
| dll_reset_pulse | output | 1 | One-cycle pulse after an accepted DLL-reset write |
| dll_pending | output | 1 | A normal-mode write is awaited |
| reserved_err | output | 1 | One-cycle pulse after a refused write |
| seq_violation | output | 1 | One-cycle pulse after an out-of-order command |

## Verification
The case hardest to reach from the ports is a violation from a command that is itself a mode-register write. Examples are a second DLL-reset write, or a refused write, while a normal write is still awaited. Purely random address words almost never reach these cases, because a random upper field is almost always reserved. The stimulus therefore draws the upper field from a weighted set: all zero, the DLL-reset pattern, a single stray bit, or fully random. Directed sequences also chain a DLL reset into each kind of interrupting command.

// File: rtl/ddr_mr_pkg.sv
package ddr_mr_pkg;

  localparam int MR_ADDR_W   = 14;
  localparam int MR_MODE_LSB = 7;
  localparam int MR_DLL_BIT  = 8;
  localparam int MR_BL_LSB   = 0;
  localparam int MR_BL_W     = 3;
  localparam int MR_BT_BIT   = 3;
  localparam int MR_LAT_LSB  = 4;
  localparam int MR_LAT_W    = 3;
  localparam int MR_BLEN_W   = 4;
  localparam int MR_LATH_W   = 3;

  typedef enum logic [1:0] {
    MR_KIND_NORMAL   = 2'd0,
    MR_KIND_DLL_RST  = 2'd1,
    MR_KIND_RESERVED = 2'd2
  } mr_kind_e;

  typedef struct packed {
    logic [MR_BLEN_W-1:0] burst_len;
    logic                 interleave;
    logic [MR_LATH_W-1:0] lat_half;
  } mr_cfg_t;

  // Burst-length code legality and beat count.
  function automatic logic bl_code_legal(input logic [MR_BL_W-1:0] code);
    return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
  endfunction

  function automatic logic [MR_BLEN_W-1:0] bl_beats(input logic [MR_BL_W-1:0] code);
    logic [MR_BLEN_W-1:0] beats;
    case (code)
      3'd1:    beats = 4'd2;
      3'd2:    beats = 4'd4;
      3'd3:    beats = 4'd8;
      default: beats = 4'd2;
    endcase
    return beats;
  endfunction

  // Latency code legality and value in half clocks.
  function automatic logic lat_code_legal(input logic [MR_LAT_W-1:0] code);
    return (code == 3'd2) || (code == 3'd3) || (code == 3'd5) || (code == 3'd6);
  endfunction

  function automatic logic [MR_LATH_W-1:0] lat_halves(input logic [MR_LAT_W-1:0] code);
    logic [MR_LATH_W-1:0] h;
    case (code)
      3'd5:    h = 3'd3;
      3'd2:    h = 3'd4;
      3'd6:    h = 3'd5;
      3'd3:    h = 3'd6;
      default: h = 3'd4;
    endcase
    return h;
  endfunction

  function automatic mr_cfg_t cfg_reset_value();
    mr_cfg_t c;
    c.burst_len  = 4'd2;
    c.interleave = 1'b0;
    c.lat_half   = 3'd4;
    return c;
  endfunction

endpackage

// File: rtl/mr_field_decode.sv
module mr_field_decode
  import ddr_mr_pkg::*;
#(
  parameter int ADDR_W   = MR_ADDR_W,
  parameter int MODE_LSB = MR_MODE_LSB,
  parameter int DLL_BIT  = MR_DLL_BIT
) (
  input  logic [ADDR_W-1:0] addr,
  output mr_kind_e          kind,
  output logic              low_legal,
  output mr_cfg_t           cfg_new
);

  localparam int UPPER_W = ADDR_W - MODE_LSB;

  logic [UPPER_W-1:0] stray_bit;

  // Every upper bit except the DLL-reset bit must be zero.
  for (genvar gi = 0; gi < UPPER_W; gi++) begin : g_upper
    if (gi + MODE_LSB == DLL_BIT) begin : g_dll
      assign stray_bit[gi] = 1'b0;
    end else begin : g_zero
      assign stray_bit[gi] = addr[gi + MODE_LSB];
    end
  end

  logic [MR_BL_W-1:0]  bl_code;
  logic [MR_LAT_W-1:0] lat_code;

  assign bl_code  = addr[MR_BL_LSB  +: MR_BL_W];
  assign lat_code = addr[MR_LAT_LSB +: MR_LAT_W];

  always_comb begin
    if (|stray_bit)          kind = MR_KIND_RESERVED;
    else if (addr[DLL_BIT])  kind = MR_KIND_DLL_RST;
    else                     kind = MR_KIND_NORMAL;
  end

  assign low_legal = bl_code_legal(bl_code) && lat_code_legal(lat_code);

  always_comb begin
    cfg_new.burst_len  = bl_beats(bl_code);
    cfg_new.interleave = addr[MR_BT_BIT];
    cfg_new.lat_half   = lat_halves(lat_code);
  end

endmodule

// File: rtl/mr_seq_tracker.sv
module mr_seq_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_seen,
  input  logic wr_normal_ok,
  input  logic wr_dll_ok,
  output logic pending,
  output logic violation
);

  logic pending_d;
  logic violation_d;

  always_comb begin
    violation_d = pending && cmd_seen && !wr_normal_ok;
    pending_d   = pending;
    if (wr_dll_ok)         pending_d = 1'b1;
    else if (wr_normal_ok) pending_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      violation <= 1'b0;
    end else begin
      pending   <= pending_d;
      violation <= violation_d;
    end
  end

endmodule

// File: rtl/mr_config_reg.sv
module mr_config_reg
  import ddr_mr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_accept,
  input  logic    wr_dll_ok,
  input  logic    wr_reserved,
  input  mr_cfg_t cfg_new,
  output mr_cfg_t cfg_q,
  output logic    dll_pulse,
  output logic    err_pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= cfg_reset_value();
      dll_pulse <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      if (wr_accept) cfg_q <= cfg_new;
      dll_pulse <= wr_dll_ok;
      err_pulse <= wr_reserved;
    end
  end

endmodule

// File: rtl/ddr_mode_decoder.sv
module ddr_mode_decoder
  import ddr_mr_pkg::*;
#(
  parameter int ADDR_W   = MR_ADDR_W,
  parameter int MODE_LSB = MR_MODE_LSB,
  parameter int DLL_BIT  = MR_DLL_BIT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mrs_stb,
  input  logic                 other_cmd_stb,
  input  logic [ADDR_W-1:0]    addr,
  output logic [MR_BLEN_W-1:0] burst_len,
  output logic                 burst_interleave,
  output logic [MR_LATH_W-1:0] rd_lat_half,
  output logic                 dll_reset_pulse,
  output logic                 dll_pending,
  output logic                 reserved_err,
  output logic                 seq_violation
);

  mr_kind_e kind;
  logic     low_legal;
  mr_cfg_t  cfg_new;
  mr_cfg_t  cfg_q;

  // Named internal events, observed by the bound checker.
  logic wr_accept;
  logic wr_normal_ok;
  logic wr_dll_ok;
  logic wr_reserved;
  logic cmd_seen;

  mr_field_decode #(
    .ADDR_W  (ADDR_W),
    .MODE_LSB(MODE_LSB),
    .DLL_BIT (DLL_BIT)
  ) u_decode (
    .addr     (addr),
    .kind     (kind),
    .low_legal(low_legal),
    .cfg_new  (cfg_new)
  );

  assign wr_accept    = mrs_stb && low_legal && (kind != MR_KIND_RESERVED);
  assign wr_normal_ok = wr_accept && (kind == MR_KIND_NORMAL);
  assign wr_dll_ok    = wr_accept && (kind == MR_KIND_DLL_RST);
  assign wr_reserved  = mrs_stb && !wr_accept;
  assign cmd_seen     = mrs_stb || other_cmd_stb;

  mr_seq_tracker u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_seen    (cmd_seen),
    .wr_normal_ok(wr_normal_ok),
    .wr_dll_ok   (wr_dll_ok),
    .pending     (dll_pending),
    .violation   (seq_violation)
  );

  mr_config_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_accept  (wr_accept),
    .wr_dll_ok  (wr_dll_ok),
    .wr_reserved(wr_reserved),
    .cfg_new    (cfg_new),
    .cfg_q      (cfg_q),
    .dll_pulse  (dll_reset_pulse),
    .err_pulse  (reserved_err)
  );

  assign burst_len        = cfg_q.burst_len;
  assign burst_interleave = cfg_q.interleave;
  assign rd_lat_half      = cfg_q.lat_half;

endmodule

// File: rtl/mr_checker.sv
module mr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_reserved,
  input logic       wr_normal_ok,
  input logic       wr_dll_ok,
  input logic [3:0] burst_len,
  input logic       burst_interleave,
  input logic [2:0] rd_lat_half,
  input logic       dll_reset_pulse,
  input logic       dll_pending,
  input logic       reserved_err,
  input logic       seq_violation
);

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reserved |=> ($stable(burst_len) && $stable(burst_interleave) && $stable(rd_lat_half)));

  // R7
  err_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reserved |=> (reserved_err && !dll_reset_pulse));

  // R5
  dll_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dll_ok |=> (dll_reset_pulse && dll_pending));

  // R5
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dll_reset_pulse, reserved_err}));

  // R8
  viol_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_violation |-> $past(dll_pending));

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_normal_ok |=> (!dll_pending && !seq_violation));

  // R2
  blen_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(burst_len) == 1 && burst_len >= 4'd2);

  // R4
  lat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lat_half >= 3'd3) && (rd_lat_half <= 3'd6));

endmodule

bind ddr_mode_decoder mr_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .wr_reserved     (wr_reserved),
  .wr_normal_ok    (wr_normal_ok),
  .wr_dll_ok       (wr_dll_ok),
  .burst_len       (burst_len),
  .burst_interleave(burst_interleave),
  .rd_lat_half     (rd_lat_half),
  .dll_reset_pulse (dll_reset_pulse),
  .dll_pending     (dll_pending),
  .reserved_err    (reserved_err),
  .seq_violation   (seq_violation)
);

// File: tb/tb_ddr_mode_decoder.sv
`timescale 1ns/1ps
module tb_ddr_mode_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mrs_stb = 1'b0;
  logic        other_cmd_stb = 1'b0;
  logic [13:0] addr = '0;
  logic [3:0]  burst_len;
  logic        burst_interleave;
  logic [2:0]  rd_lat_half;
  logic        dll_reset_pulse;
  logic        dll_pending;
  logic        reserved_err;
  logic        seq_violation;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Expected state
  logic [3:0] e_bl;
  logic       e_bt;
  logic [2:0] e_lat;
  logic       e_pend, e_dllp, e_err, e_viol;

  always #5 clk = ~clk;

  ddr_mode_decoder dut (
    .clk(clk), .rst_n(rst_n), .mrs_stb(mrs_stb), .other_cmd_stb(other_cmd_stb),
    .addr(addr), .burst_len(burst_len), .burst_interleave(burst_interleave),
    .rd_lat_half(rd_lat_half), .dll_reset_pulse(dll_reset_pulse),
    .dll_pending(dll_pending), .reserved_err(reserved_err),
    .seq_violation(seq_violation)
  );

  // Beats per burst, restated as a shift.
  function automatic int exp_beats(input int code);
    if (code >= 1 && code <= 3) return 1 << code;
    return -1;
  endfunction

  // Latency in half clocks, restated from the code table.
  function automatic int exp_halves(input int code);
    if (code == 2) return 4;
    if (code == 3) return 6;
    if (code == 5) return 3;
    if (code == 6) return 5;
    return -1;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2", "burst_len", burst_len, e_bl);
    chk("R3", "burst_interleave", burst_interleave, e_bt);
    chk("R4", "rd_lat_half", rd_lat_half, e_lat);
    chk("R5", "dll_reset_pulse", dll_reset_pulse, e_dllp);
    chk("R9", "dll_pending", dll_pending, e_pend);
    chk("R6", "reserved_err", reserved_err, e_err);
    chk("R8", "seq_violation", seq_violation, e_viol);
  endtask

  // Drive one cycle of stimulus, predict, then compare one cycle later.
  task automatic step(input logic m, input logic o, input logic [13:0] a);
    int  blv, latv;
    bit  normal, dllw, acc;
    mrs_stb = m; other_cmd_stb = o; addr = a;
    blv    = exp_beats(int'(a[2:0]));
    latv   = exp_halves(int'(a[6:4]));
    normal = (a[13:7] == 7'd0);
    dllw   = (a[13:7] == 7'b0000010);
    acc    = m && blv > 0 && latv > 0 && (normal || dllw);
    e_viol = e_pend && (m || o) && !(acc && normal);
    e_dllp = acc && dllw;
    e_err  = m && !acc;
    if (acc) begin
      e_bl = 4'(blv); e_bt = a[3]; e_lat = 3'(latv);
      e_pend = dllw;
    end
    @(negedge clk);
    compare_all();
    mrs_stb = 1'b0; other_cmd_stb = 1'b0;
  endtask

  function automatic logic [13:0] mk(input logic [6:0] up, input int lat, input bit bt, input int bl);
    return {up, 3'(lat), bt, 3'(bl)};
  endfunction

  initial begin
    #150000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    e_bl = 4'd2; e_bt = 1'b0; e_lat = 3'd4;
    e_pend = 0; e_dllp = 0; e_err = 0; e_viol = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "burst_len", burst_len, 2);
    chk("R1", "burst_interleave", burst_interleave, 0);
    chk("R1", "rd_lat_half", rd_lat_half, 4);
    chk("R1", "dll_pending", dll_pending, 0);
    chk("R1", "pulses", {dll_reset_pulse, reserved_err, seq_violation}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: other commands while idle change nothing
    step(1'b0, 1'b1, 14'h3fff);
    // R2 R3 R4: each legal code
    step(1'b1, 1'b0, mk(7'd0, 5, 1'b1, 3));
    step(1'b1, 1'b0, mk(7'd0, 6, 1'b0, 2));
    step(1'b1, 1'b0, mk(7'd0, 3, 1'b1, 1));
    step(1'b1, 1'b0, mk(7'd0, 2, 1'b0, 3));
    // R7: illegal low codes
    step(1'b1, 1'b0, mk(7'd0, 2, 1'b1, 0));
    step(1'b1, 1'b0, mk(7'd0, 7, 1'b1, 2));
    step(1'b1, 1'b0, mk(7'b0000010, 4, 1'b1, 2));
    // R6: reserved upper patterns
    step(1'b1, 1'b0, mk(7'b0000001, 3, 1'b1, 2));
    step(1'b1, 1'b0, mk(7'b0001010, 3, 1'b1, 2));
    // R5 R8: DLL reset, then each kind of interruption
    step(1'b1, 1'b0, mk(7'b0000010, 6, 1'b1, 2));
    step(1'b0, 1'b1, 14'h0);
    step(1'b1, 1'b0, mk(7'b1000000, 2, 1'b0, 1));
    step(1'b1, 1'b0, mk(7'b0000010, 5, 1'b0, 3));
    step(1'b1, 1'b1, mk(7'd0, 2, 1'b0, 2));   // R9 + R10 simultaneous strobes
    step(1'b0, 1'b0, 14'h0);

    for (int i = 0; i < 4000; i++) begin
      logic [6:0] up;
      logic [6:0] low;
      int sel;
      sel = int'($urandom % 4);
      case (sel)
        0: up = 7'd0;
        1: up = 7'b0000010;
        2: up = 7'(1 << ($urandom % 7));
        default: up = 7'($urandom);
      endcase
      if ($urandom % 10 < 7) begin
        int lc [4] = '{2, 3, 5, 6};
        low = {3'(lc[$urandom % 4]), 1'($urandom), 3'(1 + $urandom % 3)};
      end else begin
        low = 7'($urandom);
      end
      step(($urandom % 10) < 4, ($urandom % 10) < 2, {up, low});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule